// File: doc/BRIEF.md
# Quadrature Mixer with Single-Line Serial Output

This block is the frequency-shifting front end of a digital down converter. It takes one real sample per strobe. The sample is up to 16 bits wide and sits at the top of the input word. The block first converts the sample to two's complement when the offset-binary select is set. It then multiplies the sample by a cosine value and by a negated sine value. Both values come from a lookup addressed by a 32-bit phase accumulator, and the accumulator steps by the tuning word once for each accepted sample. This yields an in-phase (I) result and a quadrature (Q) result.

Mixing a unit tone leaves half its amplitude, so each product is doubled with saturation to restore unit gain. The two results then leave on one serial line: the I word, then the Q word, each sent most significant bit first. A bit-valid signal is high for every bit sent. A one-bit frame marker flags the first I bit.

Filtering and decimation belong to later stages. A sample that arrives while a frame is still being sent is discarded, and a sticky flag records the loss.

Top module: `iq_mixer_serial`

## Requirements
- R1: After reset, serData, serClkEn, frameStb and overrun are all 0, and the phase accumulator holds 0.
- R2: A sample accepted at a clock edge starts a frame at the following edge. serClkEn is then high for exactly 32 consecutive cycles and low after them, unless another frame follows directly.
- R3: frameStb is high for one cycle only, the first bit of each frame, and only while serClkEn is high.
- R4: A frame is the 16-bit I word followed by the 16-bit Q word, each MSB first, one bit per cycle. serData is 0 while serClkEn is low.
- R5: With C = round(32767·cos(2πa/1024)) and S = round(32767·sin(2πa/1024)), where a is phase bits [31:22], I = sat(floor(x·C/2^14)) and Q = sat(floor(−x·S/2^14)). The lookup stays within 1 LSB of C and S.
- R6: Each accepted sample uses the accumulator value held before the sample. The accumulator then adds tuneWord modulo 2^32, so the first sample after reset uses phase 0.
- R7: When offsetBin is 1, the input's bit 15 is inverted before mixing. When it is 0, the input is taken as two's complement.
- R8: With parameter IN_W below 16, input bits [15−IN_W:0] have no effect and are treated as zero.
- R9: A doubled result above 32767 gives 32767 and one below −32768 gives −32768. This covers −32768 × −32767.
- R10: A sample strobed while the block is busy is dropped without touching the phase. The block is busy during the cycle after an acceptance and during the first 30 bits of a frame. The strobe sets overrun, which then stays 1 until reset.
- R11: A sample strobed during bit 31 of a frame (the second-to-last bit) is accepted, and its frame follows with no idle cycle between the two. A sample strobed during bit 32 (the last bit) is also accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 16 | Input sample, MSB-justified |
| sampleValid | input | 1 | Sample strobe, one cycle per sample |
| offsetBin | input | 1 | 1: offset binary input, 0: two's complement |
| tuneWord | input | 32 | Phase step added once per accepted sample |
| serData | output | 1 | Serial I then Q bits, MSB first |
| serClkEn | output | 1 | High for every cycle that carries a frame bit |
| frameStb | output | 1 | High on the first I bit of a frame |
| overrun | output | 1 | Sticky flag for a dropped sample |

## Verification
When a strobe is sampled at edge E0, the input and phase are registered there. The product is loaded into the shifter at E1, so the first I bit and frameStb are valid in the cycle that follows E1. Bit k of the frame is valid in the cycle after edge E1+k, and serClkEn is low again after E33 unless another frame follows. The bench drives and samples on falling edges, which puts every observation in the middle of the cycle the count predicts. The bench raises the strobe at chosen bit positions of a running frame to hit both sides of the busy window. An overrun is confirmed by the flag and by the next sample, which must still use the phase the dropped sample would have consumed.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef struct packed {
    logic accept;  // capture sample and step the phase
    logic load;    // move doubled products into the shifter
    logic shift;   // advance the shifter by one bit
  } mixStrobe_t;

  // Quarter-wave sine entry k of qn steps, amplitude 2^(vw-1)-1, Q30 Taylor series.
  function automatic int quarterSin(input int k, input int qn, input int vw);
    longint x, x2, term, acc, amp, r;
    x = (longint'(k) * 64'sd3373259426) / longint'(2 * qn);
    x2 = (x * x) >>> 30;
    term = x;
    acc = x;
    for (int n = 1; n <= 6; n++) begin
      term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
      acc = acc + term;
    end
    amp = (64'sd1 <<< (vw - 1)) - 64'sd1;
    r = (acc * amp + (64'sd1 <<< 29)) >>> 30;
    if (r > amp) r = amp;
    if (r < 0) r = 0;
    return int'(r);
  endfunction

endpackage

// File: rtl/mixer_sinlut.sv
module mixer_sinlut
  import mixer_pkg::*;
#(
  parameter int AW = 10,
  parameter int VW = 16
) (
  input  logic [AW-1:0]          phaseIdx,
  output logic signed [VW-1:0]   sinVal,
  output logic signed [VW-1:0]   cosVal
);
  localparam int QN = 1 << (AW - 2);

  logic signed [VW-1:0] qtab [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam logic signed [VW-1:0] ENTRY = VW'(quarterSin(k, QN, VW));
    assign qtab[k] = ENTRY;
  end

  function automatic logic signed [VW-1:0] lookSin(input logic [AW-1:0] a);
    logic [AW-2:0] fwd;
    logic [AW-2:0] mir;
    fwd = {1'b0, a[AW-3:0]};
    mir = (AW-1)'(QN) - fwd;
    case (a[AW-1:AW-2])
      2'd0:    return qtab[fwd];
      2'd1:    return qtab[mir];
      2'd2:    return -qtab[fwd];
      default: return -qtab[mir];
    endcase
  endfunction

  logic [AW-1:0] cosIdx;
  assign cosIdx = phaseIdx + AW'(QN);
  assign sinVal = lookSin(phaseIdx);
  assign cosVal = lookSin(cosIdx);
endmodule

// File: rtl/mixer_datapath.sv
module mixer_datapath
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int IN_W     = 16,
  parameter int PHASE_W  = 32,
  parameter int LUT_AW   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  mixStrobe_t          ctl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                offsetBin,
  input  logic [PHASE_W-1:0]  tuneWord,
  output logic                serData
);
  localparam int W = SAMPLE_W;
  localparam logic [W-1:0] KEEP = {W{1'b1}} << (W - IN_W);
  localparam logic signed [2*W-1:0] HI = (2*W)'((2 ** (W - 1)) - 1);
  localparam logic signed [2*W-1:0] LO = -(2*W)'(2 ** (W - 1));

  logic signed [W-1:0]  xReg;
  logic [PHASE_W-1:0]   phaseAcc;
  logic [LUT_AW-1:0]    phaseIdx;
  logic [2*W-1:0]       shReg;
  logic [W-1:0]         xConv;
  logic signed [W-1:0]  sinV, cosV, negSin;
  logic signed [2*W-1:0] prodI, prodQ;
  logic signed [W-1:0]  dblI, dblQ;

  assign xConv = {sampleIn[W-1] ^ offsetBin, sampleIn[W-2:0]} & KEEP;

  mixer_sinlut #(.AW(LUT_AW), .VW(W)) u_lut (
    .phaseIdx (phaseIdx),
    .sinVal   (sinV),
    .cosVal   (cosV)
  );

  function automatic logic signed [W-1:0] doubleSat(input logic signed [2*W-1:0] p);
    logic signed [2*W-1:0] s;
    s = p >>> (W - 2);
    if (s > HI) return HI[W-1:0];
    if (s < LO) return LO[W-1:0];
    return s[W-1:0];
  endfunction

  assign negSin = -sinV;
  assign prodI  = (2*W)'(xReg) * (2*W)'(cosV);
  assign prodQ  = (2*W)'(xReg) * (2*W)'(negSin);
  assign dblI   = doubleSat(prodI);
  assign dblQ   = doubleSat(prodQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg     <= '0;
      phaseAcc <= '0;
      phaseIdx <= '0;
      shReg    <= '0;
    end else begin
      if (ctl.accept) begin
        xReg     <= signed'(xConv);
        phaseIdx <= phaseAcc[PHASE_W-1 -: LUT_AW];
        phaseAcc <= phaseAcc + tuneWord;
      end
      if (ctl.load) shReg <= {dblI, dblQ};
      else if (ctl.shift) shReg <= {shReg[2*W-2:0], 1'b0};
    end
  end

  assign serData = shReg[2*W-1];
endmodule

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  output mixStrobe_t ctl,
  output logic       serClkEn,
  output logic       frameStb,
  output logic       overrun
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic             loadPend, shifting, free;
  logic [CNT_W-1:0] bitCnt;

  assign free = !loadPend && (!shifting || bitCnt >= CNT_W'(FRAME_BITS - 2));
  assign ctl.accept = sampleValid && free;
  assign ctl.load   = loadPend;
  assign ctl.shift  = shifting && !loadPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPend <= 1'b0;
      shifting <= 1'b0;
      bitCnt   <= '0;
      overrun  <= 1'b0;
    end else begin
      loadPend <= ctl.accept;
      if (loadPend) begin
        shifting <= 1'b1;
        bitCnt   <= '0;
      end else if (shifting) begin
        if (bitCnt == CNT_W'(FRAME_BITS - 1)) shifting <= 1'b0;
        bitCnt <= bitCnt + 1'b1;
      end
      if (sampleValid && !free) overrun <= 1'b1;
    end
  end

  assign serClkEn = shifting;
  assign frameStb = shifting && (bitCnt == '0);
endmodule

// File: rtl/iq_mixer_serial.sv
module iq_mixer_serial
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int IN_W     = 16,
  parameter int PHASE_W  = 32,
  parameter int LUT_AW   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic                offsetBin,
  input  logic [PHASE_W-1:0]  tuneWord,
  output logic                serData,
  output logic                serClkEn,
  output logic                frameStb,
  output logic                overrun
);
  localparam int FRAME_BITS = 2 * SAMPLE_W;

  mixStrobe_t ctl;

  mixer_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .ctl         (ctl),
    .serClkEn    (serClkEn),
    .frameStb    (frameStb),
    .overrun     (overrun)
  );

  mixer_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .IN_W     (IN_W),
    .PHASE_W  (PHASE_W),
    .LUT_AW   (LUT_AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sampleIn  (sampleIn),
    .offsetBin (offsetBin),
    .tuneWord  (tuneWord),
    .serData   (serData)
  );
endmodule

// File: rtl/mixer_checker.sv
module mixer_checker #(
  parameter int FRAME_BITS = 32
) (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic serData,
  input logic serClkEn,
  input logic frameStb,
  input logic overrun
);
  localparam int GW = $clog2(FRAME_BITS) + 1;

  logic [GW-1:0] gap;
  logic          seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap       <= '0;
      seenFrame <= 1'b0;
    end else if (frameStb) begin
      gap       <= '0;
      seenFrame <= 1'b1;
    end else if (gap != {GW{1'b1}}) begin
      gap <= gap + 1'b1;
    end
  end

  p_frame_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> !frameStb);

  p_frame_in_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |-> serClkEn);

  p_word_contiguous_r2: assert property (@(posedge clk) disable iff (!rstN)
    (serClkEn && !frameStb) |-> $past(serClkEn));

  p_frame_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && seenFrame) |-> (gap >= GW'(FRAME_BITS - 1)));

  p_idle_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    !serClkEn |-> !serData);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && frameStb) |=> overrun);
endmodule

bind iq_mixer_serial mixer_checker #(.FRAME_BITS(2 * SAMPLE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .serData     (serData),
  .serClkEn    (serClkEn),
  .frameStb    (frameStb),
  .overrun     (overrun)
);

// File: tb/iq_mixer_serial_tb.sv
module iq_mixer_serial_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic        offsetBin = 1'b0;
  logic [31:0] tuneWord = '0;
  logic        serData, serClkEn, frameStb, overrun;
  logic        serData12, serClkEn12, frameStb12, overrun12;

  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;
  logic [31:0] phaseModel = '0;

  always #4 clk = ~clk;

  iq_mixer_serial u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .offsetBin(offsetBin), .tuneWord(tuneWord), .serData(serData),
    .serClkEn(serClkEn), .frameStb(frameStb), .overrun(overrun)
  );

  iq_mixer_serial #(.IN_W(12)) u_dut12 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .offsetBin(offsetBin), .tuneWord(tuneWord), .serData(serData12),
    .serClkEn(serClkEn12), .frameStb(frameStb12), .overrun(overrun12)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint roundR(input real v);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic longint lutSin(input int a);
    return roundR(32767.0 * $sin(2.0 * 3.14159265358979 * real'(a % 1024) / 1024.0));
  endfunction

  function automatic longint satDbl(input longint p);
    longint s;
    s = p >>> 14;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic checkWord(input logic [31:0] w, input logic [15:0] xin, input bit offs,
                           input int inW, input logic [31:0] ph, input string req);
    logic [15:0] c;
    longint x, cv, sv, eI, eQ, aI, aQ;
    int a;
    c = xin;
    if (offs) c[15] = ~c[15];
    c = c & (16'hFFFF << (16 - inW));
    x = longint'($signed(c));
    a = int'(ph[31:22]);
    cv = lutSin(a + 256);
    sv = lutSin(a);
    eI = satDbl(x * cv);
    eQ = satDbl(-x * sv);
    aI = longint'($signed(w[31:16]));
    aQ = longint'($signed(w[15:0]));
    check((aI - eI <= 3) && (eI - aI <= 3), {req, " I word"}, aI, eI);
    check((aQ - eQ <= 3) && (eQ - aQ <= 3), {req, " Q word"}, aQ, eQ);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phaseModel = '0;
    @(negedge clk);
  endtask

  task automatic driveSample(input logic [15:0] s);
    @(negedge clk);
    sampleIn = s;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Starts at the edge that loads the shifter; bit k is sampled at the falling edge after it.
  task automatic grabFrame(output logic [31:0] w, output logic [31:0] w12,
                           input int injectAt, input logic [15:0] injectData);
    w = '0;
    w12 = '0;
    @(posedge clk);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      w = {w[30:0], serData};
      w12 = {w12[30:0], serData12};
      check(serClkEn == 1'b1, "R2 bit valid", serClkEn, 1);
      check(frameStb == (k == 0), "R3 frame marker", frameStb, (k == 0));
      if (k == injectAt) begin
        sampleIn = injectData;
        sampleValid = 1'b1;
      end else if (k == injectAt + 1) begin
        sampleValid = 1'b0;
      end
    end
  endtask

  task automatic tReset();
    doReset();
    check(serData == 1'b0, "R1 serData", serData, 0);
    check(serClkEn == 1'b0, "R1 serClkEn", serClkEn, 0);
    check(frameStb == 1'b0, "R1 frameStb", frameStb, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
  endtask

  task automatic tBasic();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h0;
    offsetBin = 1'b0;
    driveSample(16'd1000);
    check(serClkEn == 1'b0, "R2 no bit before load edge", serClkEn, 0);
    grabFrame(w, w12, -1, '0);
    checkWord(w, 16'd1000, 1'b0, 16, phaseModel, "R4 R5 basic");
    @(negedge clk);
    check(serClkEn == 1'b0, "R2 frame ends after 32 bits", serClkEn, 0);
    check(serData == 1'b0, "R4 idle line", serData, 0);
  endtask

  task automatic tPhaseSteps();
    logic [31:0] w, w12;
    logic [15:0] xs [4];
    doReset();
    tuneWord = 32'h4000_0000;
    xs[0] = 16'd10000; xs[1] = 16'hCFC7; xs[2] = 16'd20000; xs[3] = 16'd5;
    for (int i = 0; i < 4; i++) begin
      driveSample(xs[i]);
      grabFrame(w, w12, -1, '0);
      checkWord(w, xs[i], 1'b0, 16, phaseModel, "R6 quarter steps");
      phaseModel = phaseModel + tuneWord;
    end
  endtask

  task automatic tSweep();
    logic [31:0] w, w12;
    logic [15:0] xs [5];
    doReset();
    tuneWord = 32'h0123_4567;
    xs[0] = 16'd20000; xs[1] = 16'hC568; xs[2] = 16'd7; xs[3] = 16'h7FFF; xs[4] = 16'h8000;
    for (int i = 0; i < 5; i++) begin
      driveSample(xs[i]);
      grabFrame(w, w12, -1, '0);
      checkWord(w, xs[i], 1'b0, 16, phaseModel, "R5 R6 sweep");
      phaseModel = phaseModel + tuneWord;
    end
  endtask

  task automatic tOffset();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h0;
    offsetBin = 1'b1;
    driveSample(16'hC000);
    grabFrame(w, w12, -1, '0);
    check($signed(w[31:16]) > 0, "R7 offset positive", $signed(w[31:16]), 32767);
    checkWord(w, 16'hC000, 1'b1, 16, phaseModel, "R7 offset 0xC000");
    driveSample(16'h0000);
    grabFrame(w, w12, -1, '0);
    checkWord(w, 16'h0000, 1'b1, 16, phaseModel, "R7 offset zero code");
    offsetBin = 1'b0;
  endtask

  task automatic tSaturate();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h8000_0000;
    driveSample(16'h8000);
    grabFrame(w, w12, -1, '0);
    check($signed(w[31:16]) == -32768, "R9 negative clamp", $signed(w[31:16]), -32768);
    phaseModel = phaseModel + tuneWord;
    driveSample(16'h8000);
    grabFrame(w, w12, -1, '0);
    check($signed(w[31:16]) == 32767, "R9 minus one squared", $signed(w[31:16]), 32767);
    check($signed(w[15:0]) == 0, "R9 Q at half turn", $signed(w[15:0]), 0);
  endtask

  task automatic tNarrow();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h1000_0000;
    driveSample(16'h1235);
    grabFrame(w, w12, -1, '0);
    checkWord(w12, 16'h1235, 1'b0, 12, phaseModel, "R8 low bits ignored");
    phaseModel = phaseModel + tuneWord;
    driveSample(16'h7FFF);
    grabFrame(w, w12, -1, '0);
    checkWord(w12, 16'h7FF0, 1'b0, 16, phaseModel, "R8 masked full scale");
  endtask

  task automatic tOverrun();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h2000_0000;
    driveSample(16'd9000);
    grabFrame(w, w12, 5, 16'h4444);
    checkWord(w, 16'd9000, 1'b0, 16, phaseModel, "R10 frame unharmed");
    check(overrun == 1'b1, "R10 flag set", overrun, 1);
    @(negedge clk);
    check(serClkEn == 1'b0, "R10 no frame for dropped sample", serClkEn, 0);
    phaseModel = phaseModel + tuneWord;
    driveSample(16'd9000);
    grabFrame(w, w12, -1, '0);
    checkWord(w, 16'd9000, 1'b0, 16, phaseModel, "R10 phase not stepped by drop");
    check(overrun == 1'b1, "R10 flag sticky", overrun, 1);
    doReset();
    check(overrun == 1'b0, "R1 reset clears flag", overrun, 0);
  endtask

  task automatic tBackToBack();
    logic [31:0] w, w12;
    doReset();
    tuneWord = 32'h0800_0000;
    driveSample(16'd12000);
    grabFrame(w, w12, 30, 16'hD000);
    checkWord(w, 16'd12000, 1'b0, 16, phaseModel, "R11 first frame");
    phaseModel = phaseModel + tuneWord;
    grabFrame(w, w12, 31, 16'd3000);
    checkWord(w, 16'hD000, 1'b0, 16, phaseModel, "R11 seamless frame");
    phaseModel = phaseModel + tuneWord;
    check(overrun == 1'b0, "R11 no overrun", overrun, 0);
    @(negedge clk);
    check(serClkEn == 1'b0, "R11 idle after last-bit accept", serClkEn, 0);
    grabFrame(w, w12, -1, '0);
    checkWord(w, 16'd3000, 1'b0, 16, phaseModel, "R11 last-bit accept");
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishUp();
  end

  initial begin
    tReset();
    tBasic();
    tPhaseSteps();
    tSweep();
    tOffset();
    tSaturate();
    tNarrow();
    tOverrun();
    tBackToBack();
    repeat (4) @(negedge clk);
    finishUp();
  end
endmodule